// File: doc/BRIEF.md
# Condition Nibble Vector Packer

The block walks a vector of 4-bit condition fields, one field per clock cycle. For each step it forms a masked nibble and gathers consecutive nibbles into integer destination elements. A start pulse loads the whole operation: the vector length, whether the source and the destination are vectors, a requested packing count, a destination element width code, a mapreduce flag, the select mask and the polarity map. The condition fields come through a combinational read port: the block presents a field address and expects the field on the data input in the same cycle.

Two controls set the packing. The packing code asks for a number of nibbles per element. The destination width caps that number, because an 8-, 16-, 32- or 64-bit element holds only width/4 nibbles. Any nibbles that do not fit go into the following elements. Each finished element is issued as a single indexed write holding the full element value, zero-extended to 64 bits. A scalar destination gathers nibbles into one 64-bit register, and it takes more than the first nibble only when mapreduce is set.

Top module: `cond_nibble_packer`

## Requirements
- R1: Each nibble equals (~fmap ^ field) & fmsk, where fmsk and fmap are 4-bit values and field is the 4-bit value on `cf_data`.
- R2: With `src_vec`=1, step i reads field address `src_base`+i (modulo 2^7). With `src_vec`=0, every step reads `src_base`.
- R3: For a vector destination, the nibbles per element are min(requested, width/4). Requested count: code 00=1, 01=2, 10=4, 11=8. Width: code 00=64, 01=8, 10=16, 11=32 bits.
- R4: Nibble i with per-element count k goes to element index i/k, at bits 4·(i mod k)+3 down to 4·(i mod k).
- R5: Every bit of a write that holds no nibble is zero, including all bits above the element width.
- R6: A partly filled last element is still written when the final nibble is placed. A 16-bit destination with a request of 8 fills element 0 with nibbles 0..3 and element 1 with nibbles 4..7.
- R7: For a scalar destination with mapreduce=0, exactly one write is made, at index 0, holding only nibble 0 in bits 3:0.
- R8: For a scalar destination with mapreduce=1, exactly one write is made, at index 0, holding nibble i at bits 4i+3:4i for every i < VL (VL ≤ 16).
- R9: `done` is a one-cycle pulse in the cycle after the last write. With VL=0 it pulses and no write is made. After reset, `wr_valid` and `done` are low.
- R10: Writes are issued in increasing element index order, at most one per cycle.
- R11: A start pulse that arrives while an operation is running has no effect on that operation's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| vl | input | 7 | Vector length, 0..64 |
| src_vec | input | 1 | Source fields form a vector |
| dst_vec | input | 1 | Destination is a vector of elements |
| pack_code | input | 2 | Requested nibbles per element |
| dw_code | input | 2 | Destination element width code |
| mapreduce | input | 1 | Scalar destination gathers all steps |
| fmsk | input | 4 | Nibble select mask |
| fmap | input | 4 | Nibble polarity map |
| src_base | input | 7 | First condition field address |
| cf_addr | output | 7 | Condition field read address |
| cf_data | input | 4 | Condition field read data (same cycle) |
| wr_valid | output | 1 | Element write strobe |
| wr_idx | output | 6 | Element index relative to the destination base |
| wr_data | output | 64 | Element value, zero-extended |
| done | output | 1 | Operation complete pulse |

## Verification
The assertions assume that `cf_data` is a pure function of `cf_addr` within a cycle. They also assume that a scalar destination with mapreduce set is never given a VL above 16, because placement beyond that is undefined. The stimulus drives the read port from a fixed table indexed by the address. It keeps scalar mapreduce runs at 16 steps or fewer, and starts a new operation only after the previous `done`, except in the one case that deliberately pulses start while an operation is running.

// File: rtl/cnvp_pkg.sv
package cnvp_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} cnvp_state_t;

  // element width in bits selected by the destination width code
  function automatic int unsigned elem_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 64;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

  // log2 of nibbles per element: min(request, width/4); scalar holds 16
  function automatic logic [2:0] lanes_log2(input logic [1:0] pcode,
                                            input logic [1:0] dcode,
                                            input logic       dvec);
    logic [2:0] cap;
    logic [2:0] req;
    if (!dvec) return 3'd4;
    case (dcode)
      2'b00:   cap = 3'd4;
      2'b01:   cap = 3'd1;
      2'b10:   cap = 3'd2;
      default: cap = 3'd3;
    endcase
    req = {1'b0, pcode};
    return (req < cap) ? req : cap;
  endfunction

  function automatic logic [3:0] mask_nib(input logic [3:0] msk,
                                          input logic [3:0] map,
                                          input logic [3:0] fld);
    return (~map ^ fld) & msk;
  endfunction

endpackage

// File: rtl/cnvp_nibble.sv
module cnvp_nibble
  import cnvp_pkg::*;
(
  input  logic [3:0] field,
  input  logic [3:0] msk,
  input  logic [3:0] map,
  output logic [3:0] nib
);
  assign nib = mask_nib(msk, map, field);
endmodule

// File: rtl/cnvp_slot.sv
module cnvp_slot #(
  parameter int IW = 6
) (
  input  logic [IW-1:0] step,
  input  logic [2:0]    lane_log2,
  input  logic          last,
  output logic [IW-1:0] elem,
  output logic [3:0]    slot,
  output logic          elem_end
);
  logic [IW-1:0] lane_mask;
  assign lane_mask = IW'((1 << lane_log2) - 1);
  assign elem      = step >> lane_log2;
  assign slot      = 4'(step & lane_mask);
  assign elem_end  = last || (slot == 4'(lane_mask));
endmodule

// File: rtl/cond_nibble_packer.sv
module cond_nibble_packer
  import cnvp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int AW     = 7,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int IW    = $clog2(MAX_VL),
  localparam int XW    = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic           src_vec,
  input  logic           dst_vec,
  input  logic [1:0]     pack_code,
  input  logic [1:0]     dw_code,
  input  logic           mapreduce,
  input  logic [3:0]     fmsk,
  input  logic [3:0]     fmap,
  input  logic [AW-1:0]  src_base,
  output logic [AW-1:0]  cf_addr,
  input  logic [3:0]     cf_data,
  output logic           wr_valid,
  output logic [IW-1:0]  wr_idx,
  output logic [XW-1:0]  wr_data,
  output logic           done
);

  cnvp_state_t   state;
  logic [IW-1:0] step, last_step;
  logic          src_vec_q, dst_vec_q, mr_q;
  logic [1:0]    dw_q;
  logic [2:0]    lane_q;
  logic [3:0]    msk_q, map_q;
  logic [AW-1:0] base_q;
  logic [XW-1:0] acc;
  logic          wr_last;

  // named internal events
  logic          run, is_last, elem_end;
  logic [3:0]    nib, slot;
  logic [IW-1:0] elem;
  logic [XW-1:0] merged;

  assign run     = (state == ST_RUN);
  assign is_last = (step == last_step);
  assign cf_addr = src_vec_q ? AW'(base_q + AW'(step)) : base_q;

  cnvp_nibble u_nib (.field(cf_data), .msk(msk_q), .map(map_q), .nib(nib));

  cnvp_slot #(.IW(IW)) u_slot (
    .step(step), .lane_log2(lane_q), .last(is_last),
    .elem(elem), .slot(slot), .elem_end(elem_end)
  );

  assign merged = ((slot == 4'd0) ? '0 : acc) | (XW'(nib) << {slot, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; step <= '0; last_step <= '0;
      src_vec_q <= 1'b0; dst_vec_q <= 1'b0; mr_q <= 1'b0;
      dw_q <= '0; lane_q <= '0; msk_q <= '0; map_q <= '0; base_q <= '0;
      acc <= '0; wr_valid <= 1'b0; wr_idx <= '0; wr_data <= '0;
      wr_last <= 1'b0; done <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      wr_last  <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          src_vec_q <= src_vec; dst_vec_q <= dst_vec; mr_q <= mapreduce;
          dw_q <= dw_code; lane_q <= lanes_log2(pack_code, dw_code, dst_vec);
          msk_q <= fmsk; map_q <= fmap; base_q <= src_base;
          step <= '0;
          last_step <= (dst_vec || mapreduce) ? IW'(vl - VLW'(1)) : '0;
          state <= (vl == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          acc <= merged;
          if (elem_end) begin
            wr_valid <= 1'b1;
            wr_idx   <= elem;
            wr_data  <= merged;
            wr_last  <= is_last;
          end
          if (is_last) state <= ST_FIN;
          else         step  <= step + IW'(1);
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // assertions
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_last |=> done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_scalar_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !src_vec_q |-> $stable(cf_addr));
  assert_vector_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && src_vec_q |-> cf_addr == AW'($past(cf_addr) + AW'(1)));
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && dst_vec_q |-> (wr_data >> elem_bits(dw_q)) == '0);
  assert_scalar_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !dst_vec_q && !mr_q |-> wr_data[XW-1:4] == '0 && wr_idx == '0);

endmodule

// File: tb/test_cond_nibble_packer.sv
`timescale 1ns/100ps
module test_cond_nibble_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic        src_vec = 1'b0, dst_vec = 1'b0, mapreduce = 1'b0;
  logic [1:0]  pack_code = '0, dw_code = '0;
  logic [3:0]  fmsk = '0, fmap = '0;
  logic [6:0]  src_base = '0;
  logic [6:0]  cf_addr;
  logic [3:0]  cf_data;
  logic        wr_valid;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic        done;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int cur_n = 0;
  string cur_tag = "";
  int    q_idx[$];
  logic [63:0] q_dat[$];
  logic  prev_wv = 1'b0;
  logic [3:0] cfm [0:127];

  always #2.5 clk = ~clk;

  assign cf_data = cfm[cf_addr];

  cond_nibble_packer i_cond_nibble_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_vec(src_vec),
    .dst_vec(dst_vec), .pack_code(pack_code), .dw_code(dw_code),
    .mapreduce(mapreduce), .fmsk(fmsk), .fmap(fmap), .src_base(src_base),
    .cf_addr(cf_addr), .cf_data(cf_data), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected writes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (q_idx.size() == 0) begin
          check(1'b0, "R10", "unexpected write", 64'(wr_idx), 64'hx);
        end else begin
          int ei;
          logic [63:0] ed;
          ei = q_idx.pop_front();
          ed = q_dat.pop_front();
          check(wr_idx == 6'(ei), cur_tag, "index", 64'(wr_idx), 64'(ei));
          check(wr_data == ed, cur_tag, "data", wr_data, ed);
        end
      end
      if (done) begin
        check(q_idx.size() == 0, cur_tag, "writes missing at done",
              64'(q_idx.size()), 64'd0);
        if (cur_n > 0)
          check(prev_wv, "R9", "done not one cycle after last write",
                64'(prev_wv), 64'd1);
        else
          check(!prev_wv, "R9", "write seen for VL=0", 64'(prev_wv), 64'd0);
        done_cnt++;
      end
      prev_wv = wr_valid;
    end
  end

  // driver: computes expected elements, pushes them, runs the operation
  task automatic run_op(input int n_vl, input bit sv, input bit dv,
                        input int pc, input int dw, input bit mr,
                        input int msk, input int map, input int base,
                        input string tag, input bit poke);
    logic [63:0] el [0:63];
    int wbits, per, steps, nel, target;
    for (int e = 0; e < 64; e++) el[e] = '0;
    case (dw)
      0: wbits = 64; 1: wbits = 8; 2: wbits = 16; default: wbits = 32;
    endcase
    if (dv) begin
      per = 1 << pc;
      if (per > wbits / 4) per = wbits / 4;
      steps = n_vl;
    end else begin
      per = 16;
      steps = mr ? n_vl : (n_vl > 0 ? 1 : 0);
    end
    for (int s = 0; s < steps; s++) begin
      int a;
      logic [3:0] nb;
      a = sv ? (base + s) % 128 : base;
      nb = (~4'(map) ^ cfm[a]) & 4'(msk);
      el[s / per] = el[s / per] | (64'(nb) << (4 * (s % per)));
    end
    nel = (steps + per - 1) / per;
    for (int e = 0; e < nel; e++) begin
      q_idx.push_back(e);
      q_dat.push_back(el[e]);
    end
    cur_tag = tag;
    cur_n = steps;
    target = done_cnt + 1;
    @(negedge clk);
    vl = 7'(n_vl); src_vec = sv; dst_vec = dv; pack_code = 2'(pc);
    dw_code = 2'(dw); mapreduce = mr; fmsk = 4'(msk); fmap = 4'(map);
    src_base = 7'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      vl = 7'd3; dst_vec = 1'b0; fmsk = 4'hF; fmap = 4'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt == target);
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 128; a++) cfm[a] = 4'((a * 7 + 3) % 16);
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0 && done == 1'b0, "R9", "reset outputs",
          64'({wr_valid, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(5,  1, 1, 0, 0, 0, 4'hF, 4'h0, 2,   "R1 R4 one per 64b", 0);
    run_op(6,  1, 1, 1, 0, 0, 4'h6, 4'hA, 10,  "R1 fmsk fmap mix", 0);
    run_op(4,  1, 1, 3, 0, 0, 4'h0, 4'h5, 20,  "R1 zero mask", 0);
    run_op(7,  1, 1, 3, 1, 0, 4'hF, 4'h3, 30,  "R3 8b cap", 0);
    run_op(8,  1, 1, 3, 2, 0, 4'hB, 4'h1, 40,  "R6 16b split", 0);
    run_op(16, 1, 1, 3, 3, 0, 4'hF, 4'hF, 120, "R3 R5 32b wrap", 0);
    run_op(6,  1, 1, 2, 0, 0, 4'h7, 4'h2, 50,  "R6 R10 partial", 0);
    run_op(4,  0, 1, 1, 1, 0, 4'hD, 4'h4, 60,  "R2 scalar source", 0);
    run_op(5,  1, 0, 0, 0, 0, 4'hF, 4'h9, 70,  "R7 scalar no mr", 0);
    run_op(16, 1, 0, 0, 0, 1, 4'hE, 4'h6, 80,  "R8 scalar mr", 0);
    run_op(0,  1, 1, 3, 2, 0, 4'hF, 4'h0, 0,   "R9 vl zero", 0);
    run_op(8,  1, 1, 1, 2, 0, 4'h9, 4'hC, 90,  "R11 start ignored", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired tag=%s actual=hang expected=done", cur_tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule